// File: doc/BRIEF.md
# Privileged Processor Control Register File

This block keeps the privileged control state of a 64-bit processor core: the interrupt priority level, the asynchronous trap enable and pending masks, machine-check status, the software interrupt pending set, the floating-point enable, the four stack pointers, several table base addresses and the exception address. Microcode or privileged instructions reach it through two independent ports. The fetch port reads one register by index. The store port writes one register by index with 64-bit data. Both ports may be used in the same cycle.

Each register follows its own access rule. Narrow status fields are widened with sign extension on read. Some writes merge the new data with the old value, and some of those also return the old value. Registers that may only be read, or only be written, report an error when used the other way. The kernel stack pointer can only be reached in PAL mode. Two feature inputs hide optional registers. Writes to the translation-buffer invalidate indices produce one-cycle flush pulses for the translation buffer outside this block. Process, page-table and address-space context come in on input ports. The identity register is a parameter.

Top module: `priv_regfile`

## Requirements
- R1: Each port has a one-cycle latency. An access presented with `rd_en` or `wr_en` at a clock edge raises `rd_ack` or `wr_ack` for exactly the following cycle, with its results. A read in the same cycle as a write returns the value from before that write.
- R2: The async trap enable (index 1) and async trap pending (index 2) registers are 4 bits wide. A write sets them to (old AND data[3:0]) OR data[7:4], and returns the old 4 bits zero-extended on `wr_old` with `wr_old_vld` high.
- R3: The interrupt priority level (index 0) is 5 bits wide. A write loads data[4:0] and returns the previous level zero-extended on `wr_old` with `wr_old_vld` high. Every other successful write leaves `wr_old_vld` low and `wr_old` zero, except the write described in R12.
- R4: A write to machine-check status (index 3) clears each of bits 2:0 where the data bit is 1, and loads bits 4:3 from data[4:3]. A bit of `mchk_evt` sets the matching bit 2:0. Setting takes priority over clearing in the same cycle.
- R5: A write to the software interrupt request (index 5) with level n = data[3:0] sets bit n of the 16-bit software interrupt pending set (index 4). Bit 0 never sets, so level 0 changes nothing.
- R6: Reads sign-extend the narrow fields to 64 bits: the fields of R2, R3 and R4, the 16-bit pending set, the 1-bit floating enable (index 6, written from data[0]), and the system control base (index 7, keeps data[31:0]). The process control base input (index 18) is sign-extended from bit 47.
- R7: Reading a write-only index flags `rd_err` with `rd_data` zero. The write-only indices are software request 5, alignment fixup 23, interprocessor request 24, and the invalidates 25 to 29.
- R8: Writing a read-only index flags `wr_err` and changes no state. The read-only indices are pending set 4, address space id 17, process control base 18, page table base 19, identity 20 and translation check 21. Index 21 reads as zero. Index 19 returns `ctx_pt_base`. Index 20 returns the parameter `CPU_ID`.
- R9: Any access to the kernel stack pointer (index 9) flags an error, with no effect, unless bit 0 of the exception address register (index 8, full 64 bits) is 1.
- R10: The address space id (index 17) reads as `ctx_asid` zero-extended when `feat_asid` is 1, and as zero when it is 0. The virtual bound (index 16) and the system page base (index 15) flag an error on any access while `feat_vbound` is 0.
- R11: A write to index 25 or 26 pulses `flush_all` for one cycle, aligned with `wr_ack`. A write to index 27, 28 or 29 pulses `flush_one` with `flush_addr` equal to the written data. The two pulses never occur together.
- R12: Indices 30 to 63 flag an error on both ports. The performance monitor (index 22) reads as zero. A write to it returns an old value of zero with `wr_old_vld` high.
- R13: A synchronous active-high `rst` clears every stored register and every output.
- R14: The general 64-bit registers are fully read-write: stack pointers 10, 11 and 12, processor base 13, and virtual page table base 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| feat_asid | input | 1 | Address space id feature present |
| feat_vbound | input | 1 | Virtual bound and system page base present |
| mchk_evt | input | 3 | Machine-check event pulses for status bits 2:0 |
| ctx_asid | input | 8 | Current address space id |
| ctx_pcb_base | input | 64 | Current process control block base |
| ctx_pt_base | input | 64 | Current page table base |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| rd_ack | output | 1 | Read result valid |
| rd_data | output | 64 | Read data |
| rd_err | output | 1 | Read refused |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| wr_ack | output | 1 | Write result valid |
| wr_err | output | 1 | Write refused |
| wr_old_vld | output | 1 | Old value returned |
| wr_old | output | 64 | Old field value |
| flush_all | output | 1 | Invalidate whole translation buffer |
| flush_one | output | 1 | Invalidate one translation |
| flush_addr | output | 64 | Address for `flush_one` |

## Verification
The assertions assume that `rd_en`, `wr_en` and both index buses are never unknown while reset is low. They also assume that the exception address register alone decides PAL mode, so a refused kernel stack access can be tied to that register's bit 0 in the previous cycle. The stimulus drives every request on the falling edge, holds it for exactly one clock, and lowers the enables between accesses. Each result is therefore tied to one request. Feature inputs, context inputs and `mchk_evt` change only while no request is in flight.

// File: rtl/priv_pkg.sv
package priv_pkg;

   localparam int IDX_W = 6;

   typedef enum logic [IDX_W-1:0] {
      RI_IPL       = 6'd0,
      RI_AEN       = 6'd1,
      RI_ASUM      = 6'd2,
      RI_MCHK      = 6'd3,
      RI_SWI_SUM   = 6'd4,
      RI_SWI_REQ   = 6'd5,
      RI_FPEN      = 6'd6,
      RI_SCB       = 6'd7,
      RI_EXC       = 6'd8,
      RI_KSP       = 6'd9,
      RI_ESP       = 6'd10,
      RI_SSP       = 6'd11,
      RI_USP       = 6'd12,
      RI_PROC      = 6'd13,
      RI_VPT       = 6'd14,
      RI_SYSPT     = 6'd15,
      RI_VBND      = 6'd16,
      RI_ASID      = 6'd17,
      RI_PCB       = 6'd18,
      RI_PTB       = 6'd19,
      RI_CPUID     = 6'd20,
      RI_TBCHK     = 6'd21,
      RI_PERF      = 6'd22,
      RI_FIXUP     = 6'd23,
      RI_IPI       = 6'd24,
      RI_INV_ALL   = 6'd25,
      RI_INV_PROC  = 6'd26,
      RI_INV_ONE   = 6'd27,
      RI_INV_DATA  = 6'd28,
      RI_INV_INSTR = 6'd29
   } reg_id_e;

   // the 64-bit bank occupies a contiguous index window starting at the exception address
   localparam int WIDE_BASE = 8;
   localparam int WIDE_N    = 9;

   typedef struct packed {
      logic can_rd;
      logic can_wr;
      logic pal_only;
      logic feat_gated;
   } reg_attr_t;

   function automatic reg_attr_t attr_of(input logic [IDX_W-1:0] idx);
      reg_attr_t a;
      a = '0;
      case (idx)
         RI_IPL, RI_AEN, RI_ASUM, RI_MCHK, RI_FPEN, RI_SCB, RI_EXC,
         RI_ESP, RI_SSP, RI_USP, RI_PROC, RI_VPT, RI_PERF: begin
            a.can_rd = 1'b1;
            a.can_wr = 1'b1;
         end
         RI_KSP: begin
            a.can_rd   = 1'b1;
            a.can_wr   = 1'b1;
            a.pal_only = 1'b1;
         end
         RI_SYSPT, RI_VBND: begin
            a.can_rd     = 1'b1;
            a.can_wr     = 1'b1;
            a.feat_gated = 1'b1;
         end
         RI_SWI_SUM, RI_ASID, RI_PCB, RI_PTB, RI_CPUID, RI_TBCHK:
            a.can_rd = 1'b1;
         RI_SWI_REQ, RI_FIXUP, RI_IPI, RI_INV_ALL, RI_INV_PROC,
         RI_INV_ONE, RI_INV_DATA, RI_INV_INSTR:
            a.can_wr = 1'b1;
         default: a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/priv_access_chk.sv
module priv_access_chk
   import priv_pkg::*;
#(
   parameter bit IS_WRITE = 1'b0
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             pal,
   input  logic             feat_vb,
   output logic             err
);

   reg_attr_t attr;
   logic      dir_ok;

   assign attr = attr_of(idx);

   generate
      if (IS_WRITE) begin : g_wr
         assign dir_ok = attr.can_wr;
      end else begin : g_rd
         assign dir_ok = attr.can_rd;
      end
   endgenerate

   assign err = !dir_ok
              || (attr.pal_only   && !pal)
              || (attr.feat_gated && !feat_vb);

endmodule

// File: rtl/priv_wide_bank.sv
module priv_wide_bank #(
   parameter int DATA_W = 64,
   parameter int N      = 9
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [N-1:0]              we,
   input  logic [DATA_W-1:0]         wdata,
   output logic [N-1:0][DATA_W-1:0]  q
);

   generate
      for (genvar g = 0; g < N; g++) begin : g_ent
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)        r <= '0;
            else if (we[g]) r <= wdata;
         end
         assign q[g] = r;
      end
   endgenerate

endmodule

// File: rtl/priv_narrow.sv
module priv_narrow
   import priv_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int AST_W    = 4,
   parameter int IPL_W    = 5,
   parameter int MCHK_W   = 5,
   parameter int MCHK_W1C = 3,
   parameter int SWI_W    = 16,
   parameter int SCB_W    = 32
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_go,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [MCHK_W1C-1:0]        mchk_evt,
   output logic [IPL_W-1:0]           ipl_q,
   output logic [1:0][AST_W-1:0]      ast_q,
   output logic [MCHK_W-1:0]          mchk_q,
   output logic [SWI_W-1:0]           swi_q,
   output logic                       fpen_q,
   output logic [SCB_W-1:0]           scb_q
);

   localparam int LVL_W = $clog2(SWI_W);

   logic [LVL_W-1:0]  swi_lvl;
   logic [MCHK_W-1:0] mchk_nxt;
   logic [SWI_W-1:0]  swi_nxt;

   assign swi_lvl = wr_data[LVL_W-1:0];

   // two masked trap registers share one update rule
   generate
      for (genvar g = 0; g < 2; g++) begin : g_ast
         localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(RI_AEN) + g);
         logic [AST_W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)
               r <= '0;
            else if (wr_go && wr_idx == MY_IDX)
               r <= (r & wr_data[AST_W-1:0]) | wr_data[2*AST_W-1:AST_W];
         end
         assign ast_q[g] = r;
      end
   endgenerate

   always_comb begin
      mchk_nxt = mchk_q;
      if (wr_go && wr_idx == RI_MCHK) begin
         mchk_nxt[MCHK_W1C-1:0]      = mchk_q[MCHK_W1C-1:0] & ~wr_data[MCHK_W1C-1:0];
         mchk_nxt[MCHK_W-1:MCHK_W1C] = wr_data[MCHK_W-1:MCHK_W1C];
      end
      mchk_nxt[MCHK_W1C-1:0] = mchk_nxt[MCHK_W1C-1:0] | mchk_evt;
   end

   always_comb begin
      swi_nxt = swi_q;
      if (wr_go && wr_idx == RI_SWI_REQ && swi_lvl != '0)
         swi_nxt[swi_lvl] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ipl_q  <= '0;
         mchk_q <= '0;
         swi_q  <= '0;
         fpen_q <= 1'b0;
         scb_q  <= '0;
      end else begin
         mchk_q <= mchk_nxt;
         swi_q  <= swi_nxt;
         if (wr_go && wr_idx == RI_IPL)  ipl_q  <= wr_data[IPL_W-1:0];
         if (wr_go && wr_idx == RI_FPEN) fpen_q <= wr_data[0];
         if (wr_go && wr_idx == RI_SCB)  scb_q  <= wr_data[SCB_W-1:0];
      end
   end

endmodule

// File: rtl/priv_regfile.sv
module priv_regfile
   import priv_pkg::*;
#(
   parameter int                 DATA_W   = 64,
   parameter int                 AST_W    = 4,
   parameter int                 IPL_W    = 5,
   parameter int                 MCHK_W   = 5,
   parameter int                 MCHK_W1C = 3,
   parameter int                 SWI_W    = 16,
   parameter int                 SCB_W    = 32,
   parameter int                 VA_W     = 48,
   parameter int                 ASID_W   = 8,
   parameter logic [DATA_W-1:0]  CPU_ID   = '0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 feat_asid,
   input  logic                 feat_vbound,
   input  logic [MCHK_W1C-1:0]  mchk_evt,
   input  logic [ASID_W-1:0]    ctx_asid,
   input  logic [DATA_W-1:0]    ctx_pcb_base,
   input  logic [DATA_W-1:0]    ctx_pt_base,
   input  logic                 rd_en,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic                 rd_ack,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 rd_err,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 wr_ack,
   output logic                 wr_err,
   output logic                 wr_old_vld,
   output logic [DATA_W-1:0]    wr_old,
   output logic                 flush_all,
   output logic                 flush_one,
   output logic [DATA_W-1:0]    flush_addr
);

   // elaboration-time parameter checks
   generate
      if (2 * AST_W > DATA_W) begin : g_bad_ast
         $error("priv_regfile: AST_W too wide for DATA_W");
      end
      if (MCHK_W1C >= MCHK_W) begin : g_bad_mchk
         $error("priv_regfile: MCHK_W1C must be below MCHK_W");
      end
      if ((1 << $clog2(SWI_W)) != SWI_W) begin : g_bad_swi
         $error("priv_regfile: SWI_W must be a power of two");
      end
      if (SCB_W > DATA_W || VA_W > DATA_W || ASID_W > DATA_W || IPL_W > DATA_W) begin : g_bad_w
         $error("priv_regfile: field wider than DATA_W");
      end
   endgenerate

   function automatic logic [DATA_W-1:0] sext(input logic [DATA_W-1:0] v, input int w);
      logic [DATA_W-1:0] r;
      r = v;
      for (int i = 0; i < DATA_W; i++)
         if (i >= w) r[i] = v[w-1];
      return r;
   endfunction

   logic                         rd_err_c, wr_err_c, wr_go, pal_mode;
   logic [WIDE_N-1:0]            wide_we;
   logic [WIDE_N-1:0][DATA_W-1:0] wide_q;
   logic [IPL_W-1:0]             ipl_q;
   logic [1:0][AST_W-1:0]        ast_q;
   logic [MCHK_W-1:0]            mchk_q;
   logic [SWI_W-1:0]             swi_q;
   logic                         fpen_q;
   logic [SCB_W-1:0]             scb_q;
   logic [DATA_W-1:0]            rd_val, old_val;
   logic                         old_sel, is_fall, is_fone;

   priv_access_chk #(.IS_WRITE(1'b0)) u_rd_chk (
      .idx(rd_idx), .pal(pal_mode), .feat_vb(feat_vbound), .err(rd_err_c)
   );

   priv_access_chk #(.IS_WRITE(1'b1)) u_wr_chk (
      .idx(wr_idx), .pal(pal_mode), .feat_vb(feat_vbound), .err(wr_err_c)
   );

   assign wr_go = wr_en && !wr_err_c;

   generate
      for (genvar g = 0; g < WIDE_N; g++) begin : g_wwe
         assign wide_we[g] = wr_go && (wr_idx == IDX_W'(WIDE_BASE + g));
      end
   endgenerate

   priv_wide_bank #(.DATA_W(DATA_W), .N(WIDE_N)) u_wide (
      .clk(clk), .rst(rst), .we(wide_we), .wdata(wr_data), .q(wide_q)
   );

   // slot 0 of the wide bank is the exception address; its bit 0 marks PAL mode
   assign pal_mode = wide_q[0][0];

   priv_narrow #(
      .DATA_W(DATA_W), .AST_W(AST_W), .IPL_W(IPL_W), .MCHK_W(MCHK_W),
      .MCHK_W1C(MCHK_W1C), .SWI_W(SWI_W), .SCB_W(SCB_W)
   ) u_narrow (
      .clk(clk), .rst(rst), .wr_go(wr_go), .wr_idx(wr_idx), .wr_data(wr_data),
      .mchk_evt(mchk_evt), .ipl_q(ipl_q), .ast_q(ast_q), .mchk_q(mchk_q),
      .swi_q(swi_q), .fpen_q(fpen_q), .scb_q(scb_q)
   );

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < WIDE_N; g++)
         if (rd_idx == IDX_W'(WIDE_BASE + g)) rd_val = wide_q[g];
      case (rd_idx)
         RI_IPL:     rd_val = sext(DATA_W'(ipl_q), IPL_W);
         RI_AEN:     rd_val = sext(DATA_W'(ast_q[0]), AST_W);
         RI_ASUM:    rd_val = sext(DATA_W'(ast_q[1]), AST_W);
         RI_MCHK:    rd_val = sext(DATA_W'(mchk_q), MCHK_W);
         RI_SWI_SUM: rd_val = sext(DATA_W'(swi_q), SWI_W);
         RI_FPEN:    rd_val = sext(DATA_W'(fpen_q), 1);
         RI_SCB:     rd_val = sext(DATA_W'(scb_q), SCB_W);
         RI_ASID:    rd_val = feat_asid ? DATA_W'(ctx_asid) : '0;
         RI_PCB:     rd_val = sext(ctx_pcb_base, VA_W);
         RI_PTB:     rd_val = ctx_pt_base;
         RI_CPUID:   rd_val = CPU_ID;
         default:    ;
      endcase
   end

   always_comb begin
      old_sel = 1'b0;
      old_val = '0;
      case (wr_idx)
         RI_IPL:  begin old_sel = 1'b1; old_val = DATA_W'(ipl_q);    end
         RI_AEN:  begin old_sel = 1'b1; old_val = DATA_W'(ast_q[0]); end
         RI_ASUM: begin old_sel = 1'b1; old_val = DATA_W'(ast_q[1]); end
         RI_PERF: begin old_sel = 1'b1; old_val = '0;                end
         default: ;
      endcase
   end

   assign is_fall = (wr_idx == RI_INV_ALL) || (wr_idx == RI_INV_PROC);
   assign is_fone = (wr_idx == RI_INV_ONE) || (wr_idx == RI_INV_DATA)
                 || (wr_idx == RI_INV_INSTR);

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ack     <= 1'b0;
         rd_err     <= 1'b0;
         rd_data    <= '0;
         wr_ack     <= 1'b0;
         wr_err     <= 1'b0;
         wr_old_vld <= 1'b0;
         wr_old     <= '0;
         flush_all  <= 1'b0;
         flush_one  <= 1'b0;
         flush_addr <= '0;
      end else begin
         rd_ack     <= rd_en;
         rd_err     <= rd_en && rd_err_c;
         rd_data    <= (rd_en && !rd_err_c) ? rd_val : '0;
         wr_ack     <= wr_en;
         wr_err     <= wr_en && wr_err_c;
         wr_old_vld <= wr_go && old_sel;
         wr_old     <= (wr_go && old_sel) ? old_val : '0;
         flush_all  <= wr_go && is_fall;
         flush_one  <= wr_go && is_fone;
         flush_addr <= (wr_go && is_fone) ? wr_data : '0;
      end
   end

endmodule

// File: rtl/priv_regfile_chk.sv
module priv_regfile_chk
   import priv_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_en,
   input logic [IDX_W-1:0]  rd_idx,
   input logic              rd_ack,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_err,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic              wr_ack,
   input logic              wr_err,
   input logic              flush_all,
   input logic              flush_one,
   input logic              pal_mode
);

   p_rd_ack_r1: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rd_ack);

   p_wr_ack_r1: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> wr_ack);

   p_fpen_sext_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_idx == RI_FPEN) |=> (rd_data == '0 || rd_data == '1));

   p_wo_read_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_idx == RI_SWI_REQ) |=> (rd_err && rd_data == '0));

   p_ro_write_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_idx == RI_ASID || wr_idx == RI_CPUID)) |=> wr_err);

   p_ksp_pal_r9: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_idx == RI_KSP && !pal_mode) |=> rd_err);

   p_flush_excl_r11: assert property (@(posedge clk) disable iff (rst)
      !(flush_all && flush_one));

   p_flush_src_r11: assert property (@(posedge clk) disable iff (rst)
      (flush_all || flush_one) |-> (wr_ack && !wr_err));

   p_unassigned_r12: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_idx > RI_INV_INSTR) |=> rd_err);

endmodule

bind priv_regfile priv_regfile_chk #(.DATA_W(DATA_W)) u_priv_chk (
   .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .rd_ack(rd_ack),
   .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_ack(wr_ack), .wr_err(wr_err), .flush_all(flush_all),
   .flush_one(flush_one), .pal_mode(pal_mode)
);

// File: tb/test_priv_regfile.sv
module test_priv_regfile;
   import priv_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        feat_asid = 1'b0, feat_vbound = 1'b0;
   logic [2:0]  mchk_evt = '0;
   logic [7:0]  ctx_asid = 8'h5A;
   logic [63:0] ctx_pcb_base = 64'h0000_8000_0000_1000;
   logic [63:0] ctx_pt_base  = 64'h0000_0012_3456_0000;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [5:0]  rd_idx = '0, wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic        rd_ack, rd_err, wr_ack, wr_err, wr_old_vld, flush_all, flush_one;
   logic [63:0] rd_data, wr_old, flush_addr;

   always #5 clk = ~clk;

   priv_regfile #(.CPU_ID(64'h7)) i_priv_regfile (
      .clk(clk), .rst(rst), .feat_asid(feat_asid), .feat_vbound(feat_vbound),
      .mchk_evt(mchk_evt), .ctx_asid(ctx_asid), .ctx_pcb_base(ctx_pcb_base),
      .ctx_pt_base(ctx_pt_base), .rd_en(rd_en), .rd_idx(rd_idx), .rd_ack(rd_ack),
      .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err), .wr_old_vld(wr_old_vld),
      .wr_old(wr_old), .flush_all(flush_all), .flush_one(flush_one),
      .flush_addr(flush_addr)
   );

   typedef struct {
      logic [64:0] v;
      string       tag;
   } rd_item_t;

   typedef struct {
      logic [194:0] v;
      string        tag;
   } wr_item_t;

   rd_item_t rd_q[$];
   wr_item_t wr_q[$];
   int  n_tests = 0, n_fail = 0;
   bit  done = 1'b0;
   localparam logic [63:0] ONES = '1;

   task automatic check(input string tag, input logic [194:0] act, input logic [194:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: results are sampled on the falling edge after the registering edge
   always @(negedge clk) begin
      if (!rst) begin
         if (rd_ack) begin
            if (rd_q.size() == 0) check("R1 unexpected rd_ack", 195'd1, 195'd0);
            else begin
               rd_item_t it;
               it = rd_q.pop_front();
               check(it.tag, 195'({rd_err, rd_data}), 195'(it.v));
            end
         end
         if (wr_ack) begin
            if (wr_q.size() == 0) check("R1 unexpected wr_ack", 195'd1, 195'd0);
            else begin
               wr_item_t it;
               it = wr_q.pop_front();
               check(it.tag, {wr_err, wr_old_vld, wr_old, flush_all, flush_one, flush_addr}, it.v);
            end
         end
      end
   end

   task automatic acc(input logic re, input logic [5:0] ri, input logic [63:0] rd_exp, input logic re_exp,
                      input logic we, input logic [5:0] wi, input logic [63:0] wd,
                      input logic we_exp, input logic ov_exp, input logic [63:0] old_exp,
                      input logic fa_exp, input logic fo_exp, input logic [63:0] fad_exp,
                      input string tag);
      @(negedge clk);
      rd_en = re; rd_idx = ri; wr_en = we; wr_idx = wi; wr_data = wd;
      if (re) rd_q.push_back('{v: {re_exp, rd_exp}, tag: {tag, " read"}});
      if (we) wr_q.push_back('{v: {we_exp, ov_exp, old_exp, fa_exp, fo_exp, fad_exp}, tag: {tag, " write"}});
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] ri, input logic [63:0] d, input logic e, input string tag);
      acc(1'b1, ri, d, e, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, tag);
   endtask

   task automatic wr(input logic [5:0] wi, input logic [63:0] wd, input logic e,
                     input logic ov, input logic [63:0] old, input string tag);
      acc(1'b0, '0, '0, 1'b0, 1'b1, wi, wd, e, ov, old, 1'b0, 1'b0, '0, tag);
   endtask

   task automatic wrf(input logic [5:0] wi, input logic [63:0] wd, input logic fa,
                      input logic fo, input logic [63:0] fad, input string tag);
      acc(1'b0, '0, '0, 1'b0, 1'b1, wi, wd, 1'b0, 1'b0, '0, fa, fo, fad, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R13 reset state at the ports
      check("R13 outputs after reset",
            195'({rd_ack, rd_err, rd_data, wr_ack, wr_err, wr_old_vld, flush_all, flush_one}), 195'd0);
      rd(RI_IPL, 64'h0, 1'b0, "R13 level cleared");
      rd(RI_EXC, 64'h0, 1'b0, "R13 exception address cleared");

      // R3 level write and old value
      wr(RI_IPL, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 64'h0, "R3 level load");
      rd(RI_IPL, ONES, 1'b0, "R6 level sign extension");
      wr(RI_IPL, 64'h0A, 1'b0, 1'b1, 64'h1F, "R3 level old value");
      rd(RI_IPL, 64'h0A, 1'b0, "R3 level readback");
      // R1 read and write of the same register in one cycle
      acc(1'b1, RI_IPL, 64'h0A, 1'b0, 1'b1, RI_IPL, 64'h3, 1'b0, 1'b1, 64'h0A,
          1'b0, 1'b0, '0, "R1 same-cycle");
      rd(RI_IPL, 64'h3, 1'b0, "R1 after same-cycle write");

      // R2 masked trap registers
      wr(RI_AEN, 64'hF0, 1'b0, 1'b1, 64'h0, "R2 enable set");
      wr(RI_AEN, 64'h03, 1'b0, 1'b1, 64'hF, "R2 enable and-mask");
      rd(RI_AEN, 64'h3, 1'b0, "R2 enable value");
      wr(RI_AEN, 64'h85, 1'b0, 1'b1, 64'h3, "R2 enable and-or");
      rd(RI_AEN, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, "R6 enable sign extension");
      wr(RI_ASUM, 64'h20, 1'b0, 1'b1, 64'h0, "R2 pending set");
      rd(RI_ASUM, 64'h2, 1'b0, "R2 pending value");

      // R4 machine-check status
      @(negedge clk); mchk_evt = 3'b101;
      @(negedge clk); mchk_evt = 3'b000;
      rd(RI_MCHK, 64'h5, 1'b0, "R4 events set");
      wr(RI_MCHK, 64'h11, 1'b0, 1'b0, 64'h0, "R4 clear and load");
      rd(RI_MCHK, 64'hFFFF_FFFF_FFFF_FFF4, 1'b0, "R4 status after write");

      // R5 software interrupt requests
      wr(RI_SWI_REQ, 64'h0, 1'b0, 1'b0, 64'h0, "R5 level zero");
      rd(RI_SWI_SUM, 64'h0, 1'b0, "R5 level zero no effect");
      wr(RI_SWI_REQ, 64'h5, 1'b0, 1'b0, 64'h0, "R5 level 5");
      wr(RI_SWI_REQ, 64'hF, 1'b0, 1'b0, 64'h0, "R5 level 15");
      wr(RI_SWI_REQ, 64'h30, 1'b0, 1'b0, 64'h0, "R5 low nibble zero");
      rd(RI_SWI_SUM, 64'hFFFF_FFFF_FFFF_8020, 1'b0, "R5 pending set");

      // R6 floating enable and system control base
      wr(RI_FPEN, 64'h1, 1'b0, 1'b0, 64'h0, "R6 fp enable set");
      rd(RI_FPEN, ONES, 1'b0, "R6 fp enable sign extension");
      wr(RI_FPEN, 64'h2, 1'b0, 1'b0, 64'h0, "R6 fp enable clear");
      rd(RI_FPEN, 64'h0, 1'b0, "R6 fp enable zero");
      wr(RI_SCB, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 64'h0, "R6 control base write");
      rd(RI_SCB, 64'hFFFF_FFFF_9ABC_DEF0, 1'b0, "R6 control base sign extension");
      rd(RI_PCB, 64'hFFFF_8000_0000_1000, 1'b0, "R6 process base sign extension");

      // R7 write-only reads
      rd(RI_SWI_REQ, 64'h0, 1'b1, "R7 request read");
      rd(RI_FIXUP, 64'h0, 1'b1, "R7 fixup read");
      rd(RI_IPI, 64'h0, 1'b1, "R7 ipi read");
      rd(RI_INV_ALL, 64'h0, 1'b1, "R7 invalidate read");
      wr(RI_FIXUP, 64'h1, 1'b0, 1'b0, 64'h0, "R7 fixup write accepted");

      // R8 read-only writes
      wr(RI_ASID, 64'h1, 1'b1, 1'b0, 64'h0, "R8 asid write");
      wr(RI_CPUID, 64'h1, 1'b1, 1'b0, 64'h0, "R8 identity write");
      wr(RI_SWI_SUM, 64'h0, 1'b1, 1'b0, 64'h0, "R8 pending write");
      rd(RI_SWI_SUM, 64'hFFFF_FFFF_FFFF_8020, 1'b0, "R8 pending unchanged");
      rd(RI_CPUID, 64'h7, 1'b0, "R8 identity read");
      rd(RI_PTB, 64'h0000_0012_3456_0000, 1'b0, "R8 page table base read");
      rd(RI_TBCHK, 64'h0, 1'b0, "R8 translation check read");

      // R9 kernel stack gating
      rd(RI_KSP, 64'h0, 1'b1, "R9 read outside PAL");
      wr(RI_KSP, 64'h55, 1'b1, 1'b0, 64'h0, "R9 write outside PAL");
      wr(RI_EXC, 64'h1001, 1'b0, 1'b0, 64'h0, "R9 enter PAL");
      rd(RI_KSP, 64'h0, 1'b0, "R9 refused write had no effect");
      wr(RI_KSP, 64'hAAAA, 1'b0, 1'b0, 64'h0, "R9 write in PAL");
      rd(RI_KSP, 64'hAAAA, 1'b0, "R9 read in PAL");

      // R10 feature gating
      rd(RI_ASID, 64'h0, 1'b0, "R10 asid hidden");
      rd(RI_VBND, 64'h0, 1'b1, "R10 bound read disabled");
      wr(RI_SYSPT, 64'h9, 1'b1, 1'b0, 64'h0, "R10 system base write disabled");
      @(negedge clk); feat_asid = 1'b1; feat_vbound = 1'b1;
      rd(RI_ASID, 64'h5A, 1'b0, "R10 asid shown");
      wr(RI_VBND, 64'hBEEF, 1'b0, 1'b0, 64'h0, "R10 bound write enabled");
      rd(RI_VBND, 64'hBEEF, 1'b0, "R10 bound read enabled");
      rd(RI_SYSPT, 64'h0, 1'b0, "R10 refused write had no effect");

      // R14 plain 64-bit registers
      wr(RI_USP, 64'hDEAD_BEEF_0123_4567, 1'b0, 1'b0, 64'h0, "R14 user stack write");
      rd(RI_USP, 64'hDEAD_BEEF_0123_4567, 1'b0, "R14 user stack read");
      wr(RI_VPT, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 64'h0, "R14 page table write");
      rd(RI_VPT, 64'h8000_0000_0000_0000, 1'b0, "R14 page table read");

      // R11 flush pulses
      wrf(RI_INV_ALL, 64'h123, 1'b1, 1'b0, 64'h0, "R11 invalidate all");
      wrf(RI_INV_PROC, 64'h0, 1'b1, 1'b0, 64'h0, "R11 invalidate process");
      wrf(RI_INV_ONE, 64'h0DEA_D000, 1'b0, 1'b1, 64'h0DEA_D000, "R11 invalidate one");
      wrf(RI_INV_INSTR, 64'h4000, 1'b0, 1'b1, 64'h4000, "R11 invalidate instr");

      // R12 unassigned indices and performance monitor
      rd(6'd40, 64'h0, 1'b1, "R12 unassigned read");
      wr(6'd63, 64'h1, 1'b1, 1'b0, 64'h0, "R12 unassigned write");
      rd(RI_PERF, 64'h0, 1'b0, "R12 perf read");
      wr(RI_PERF, 64'hFF, 1'b0, 1'b1, 64'h0, "R12 perf old value");

      repeat (3) @(negedge clk);
      check("R1 all results seen", 195'(rd_q.size() + wr_q.size()), 195'd0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule